// File: doc/BRIEF.md
# Pipeline Bypass Selector and Load-Use Interlock

This block resolves read-after-write data hazards in a five-stage in-order pipeline. Every cycle it looks at the source register numbers of the instruction about to execute. It compares them with the destination numbers of the two older instructions that still sit in the EX/MEM and MEM/WB pipeline registers. From that comparison it drives the select codes of the two ALU operand multiplexers. It also drives the select of the data-memory write-data multiplexer, so a store can write a value that a load fetched one instruction earlier.

Some dependences cannot be bypassed. The typical case is an instruction in decode that reads the register a load in execute will return. For that case the block raises a hold for the program counter and the IF/ID register. At the same time it marks the slot that enters execute as a bubble. The bubble travels down the pipe with its register-write and memory-write enables forced to zero. The block is purely combinational. The register file writes in the first half of a cycle and reads in the second, so no path from write-back to decode is needed.

Top module: `hazard_bypass`

## Requirements
- R1: When the EX/MEM instruction writes a nonzero register that equals the execute-stage rs, and that instruction is not a load, `selA` is 1 (EX/MEM ALU result).
- R2: When only MEM/WB matches a source, the select is 2 if the MEM/WB instruction is not a load (ALU result) and 3 if it is a load (loaded data). With no match the select is 0 (register file).
- R3: The execute-stage rt field gets the same select codes on `selB` as rs gets on `selA`.
- R4: When EX/MEM and MEM/WB both match the same source, the EX/MEM code wins.
- R5: Register 0 never matches anything. A stage whose register-write enable is low never matches.
- R6: A producer's destination is its rd field when its use-rd flag is 1, and its rt field otherwise.
- R7: A load held in EX/MEM is never a bypass source for the ALU operands.
- R8: `selStore` is 1 when the EX/MEM instruction is a store whose rt equals the nonzero rt destination of a register-writing load in MEM/WB. Otherwise it is 0.
- R9: `holdFront` and `bubble` are both 1 when the ID/EX instruction is a register-writing load with a nonzero rt, and the decode instruction reads that register as rs, or as rt when it reads rt and is not a store.
- R10: A store in decode whose only dependence on the load in ID/EX is its data operand (rt) causes no stall.
- R11: While `bubble` is 1, `exRegWriteNext` and `exMemWriteNext` are 0. Otherwise they equal `idRegWrite` and `idMemWrite`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exRs | input | RB | rs of the instruction in execute |
| exRt | input | RB | rt of the instruction in execute |
| exmemRt | input | RB | rt field held in EX/MEM |
| exmemRd | input | RB | rd field held in EX/MEM |
| exmemUseRd | input | 1 | EX/MEM destination is rd |
| exmemRegWrite | input | 1 | EX/MEM writes a register |
| exmemIsLoad | input | 1 | EX/MEM holds a load |
| exmemIsStore | input | 1 | EX/MEM holds a store |
| memwbRt | input | RB | rt field held in MEM/WB |
| memwbRd | input | RB | rd field held in MEM/WB |
| memwbUseRd | input | 1 | MEM/WB destination is rd |
| memwbRegWrite | input | 1 | MEM/WB writes a register |
| memwbIsLoad | input | 1 | MEM/WB holds a load |
| idRs | input | RB | rs of the instruction in decode |
| idRt | input | RB | rt of the instruction in decode |
| idReadsRt | input | 1 | decode instruction reads rt |
| idIsStore | input | 1 | decode instruction is a store |
| idexRt | input | RB | rt (load destination) held in ID/EX |
| idexIsLoad | input | 1 | ID/EX holds a load |
| idexRegWrite | input | 1 | ID/EX writes a register |
| idRegWrite | input | 1 | register-write enable decoded in ID |
| idMemWrite | input | 1 | memory-write enable decoded in ID |
| selA | output | 2 | ALU operand A select (0 reg, 1 EX/MEM ALU, 2 MEM/WB ALU, 3 MEM/WB load) |
| selB | output | 2 | ALU operand B select, same coding |
| selStore | output | 1 | store data taken from MEM/WB load data |
| holdFront | output | 1 | hold PC and IF/ID |
| bubble | output | 1 | slot entering execute is a bubble |
| exRegWriteNext | output | 1 | register-write enable into ID/EX |
| exMemWriteNext | output | 1 | memory-write enable into ID/EX |

## Verification
Random stimulus draws register numbers from a small range, so that matches, double matches and register-0 cases all happen often. Every output is compared with reference functions. Directed cases separate the individual input patterns:
- A match in EX/MEM only, and a match in MEM/WB only with both an ALU result and a load. These tell the four select codes apart.
- A match in both stages, which exposes a wrong priority.
- Register 0, and a producer with its write enable low, which expose false matches.
- A load in EX/MEM, which exposes an illegal bypass.
- A load followed by a store that depends on it only through its data operand, which must not stall. The same load followed by a store that uses it as its base address must stall.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    OPND_REG        = 2'd0,
    OPND_EXMEM_ALU  = 2'd1,
    OPND_MEMWB_ALU  = 2'd2,
    OPND_MEMWB_LOAD = 2'd3
  } opndSel_e;

  typedef struct packed {
    logic holdFront;
    logic bubble;
  } strobes_t;
endpackage

// File: rtl/hb_interlock.sv
module hb_interlock
  import hb_pkg::*;
#(
  parameter int RB = 5
) (
  input  logic [RB-1:0] idRs,
  input  logic [RB-1:0] idRt,
  input  logic          idReadsRt,
  input  logic          idIsStore,
  input  logic [RB-1:0] idexRt,
  input  logic          idexIsLoad,
  input  logic          idexRegWrite,
  output strobes_t      ctl
);
  logic loadPending, rsHit, rtHit, stall;

  assign loadPending = idexIsLoad && idexRegWrite && (idexRt != '0);
  assign rsHit       = (idRs == idexRt);
  // a store's data operand is fed later from MEM/WB load data
  assign rtHit       = idReadsRt && !idIsStore && (idRt == idexRt);
  assign stall       = loadPending && (rsHit || rtHit);

  always_comb begin
    ctl.holdFront = stall;
    ctl.bubble    = stall;
  end

  always_comb begin
    if (ctl.bubble) begin
      assert_stall_needs_load_R9: assert (idexIsLoad && idexRegWrite)
        else $error("stall without a load in ID/EX");
    end
  end
endmodule

// File: rtl/hb_bypass.sv
module hb_bypass
  import hb_pkg::*;
#(
  parameter int RB = 5,
  localparam int NSRC = 2
) (
  input  logic [RB-1:0] exRs,
  input  logic [RB-1:0] exRt,
  input  logic [RB-1:0] exmemRt,
  input  logic [RB-1:0] exmemRd,
  input  logic          exmemUseRd,
  input  logic          exmemRegWrite,
  input  logic          exmemIsLoad,
  input  logic          exmemIsStore,
  input  logic [RB-1:0] memwbRt,
  input  logic [RB-1:0] memwbRd,
  input  logic          memwbUseRd,
  input  logic          memwbRegWrite,
  input  logic          memwbIsLoad,
  input  logic          idRegWrite,
  input  logic          idMemWrite,
  input  strobes_t      ctl,
  output logic [1:0]    selA,
  output logic [1:0]    selB,
  output logic          selStore,
  output logic          exRegWriteNext,
  output logic          exMemWriteNext
);
  logic [RB-1:0] exmemDest, memwbDest;
  logic          exmemLive, memwbLive;
  logic [RB-1:0] srcReg [NSRC];

  assign exmemDest = exmemUseRd ? exmemRd : exmemRt;
  assign memwbDest = memwbUseRd ? memwbRd : memwbRt;
  assign exmemLive = exmemRegWrite && !exmemIsLoad && (exmemDest != '0);
  assign memwbLive = memwbRegWrite && (memwbDest != '0);
  assign srcReg[0] = exRs;
  assign srcReg[1] = exRt;

  for (genvar g = 0; g < NSRC; g++) begin : gOpnd
    opndSel_e pick;
    always_comb begin
      if (exmemLive && (srcReg[g] == exmemDest))
        pick = OPND_EXMEM_ALU;
      else if (memwbLive && (srcReg[g] == memwbDest))
        pick = memwbIsLoad ? OPND_MEMWB_LOAD : OPND_MEMWB_ALU;
      else
        pick = OPND_REG;
    end
  end

  assign selA = gOpnd[0].pick;
  assign selB = gOpnd[1].pick;

  assign selStore = exmemIsStore && memwbRegWrite && memwbIsLoad &&
                    (memwbRt != '0) && (exmemRt == memwbRt);

  assign exRegWriteNext = idRegWrite && !ctl.bubble;
  assign exMemWriteNext = idMemWrite && !ctl.bubble;

  always_comb begin
    if (exmemIsLoad) begin
      assert_no_load_bypass_R7: assert (selA != 2'd1 && selB != 2'd1)
        else $error("load in EX/MEM used as ALU bypass");
    end
    if (selStore) begin
      assert_store_src_load_R8: assert (memwbIsLoad && exmemIsStore)
        else $error("store data select without load/store pair");
    end
  end
endmodule

// File: rtl/hazard_bypass.sv
module hazard_bypass
  import hb_pkg::*;
#(
  parameter int RB = 5
) (
  input  logic [RB-1:0] exRs,
  input  logic [RB-1:0] exRt,
  input  logic [RB-1:0] exmemRt,
  input  logic [RB-1:0] exmemRd,
  input  logic          exmemUseRd,
  input  logic          exmemRegWrite,
  input  logic          exmemIsLoad,
  input  logic          exmemIsStore,
  input  logic [RB-1:0] memwbRt,
  input  logic [RB-1:0] memwbRd,
  input  logic          memwbUseRd,
  input  logic          memwbRegWrite,
  input  logic          memwbIsLoad,
  input  logic [RB-1:0] idRs,
  input  logic [RB-1:0] idRt,
  input  logic          idReadsRt,
  input  logic          idIsStore,
  input  logic [RB-1:0] idexRt,
  input  logic          idexIsLoad,
  input  logic          idexRegWrite,
  input  logic          idRegWrite,
  input  logic          idMemWrite,
  output logic [1:0]    selA,
  output logic [1:0]    selB,
  output logic          selStore,
  output logic          holdFront,
  output logic          bubble,
  output logic          exRegWriteNext,
  output logic          exMemWriteNext
);
  strobes_t ctl;

  hb_interlock #(.RB(RB)) u_ctl (
    .idRs(idRs), .idRt(idRt), .idReadsRt(idReadsRt), .idIsStore(idIsStore),
    .idexRt(idexRt), .idexIsLoad(idexIsLoad), .idexRegWrite(idexRegWrite),
    .ctl(ctl)
  );

  hb_bypass #(.RB(RB)) u_dp (
    .exRs(exRs), .exRt(exRt),
    .exmemRt(exmemRt), .exmemRd(exmemRd), .exmemUseRd(exmemUseRd),
    .exmemRegWrite(exmemRegWrite), .exmemIsLoad(exmemIsLoad), .exmemIsStore(exmemIsStore),
    .memwbRt(memwbRt), .memwbRd(memwbRd), .memwbUseRd(memwbUseRd),
    .memwbRegWrite(memwbRegWrite), .memwbIsLoad(memwbIsLoad),
    .idRegWrite(idRegWrite), .idMemWrite(idMemWrite), .ctl(ctl),
    .selA(selA), .selB(selB), .selStore(selStore),
    .exRegWriteNext(exRegWriteNext), .exMemWriteNext(exMemWriteNext)
  );

  assign holdFront = ctl.holdFront;
  assign bubble    = ctl.bubble;

  always_comb begin
    if (bubble) begin
      assert_bubble_quiet_R11: assert (!exRegWriteNext && !exMemWriteNext)
        else $error("bubble carries a write enable");
    end
    if (exRs == '0) begin
      assert_zero_rs_R5: assert (selA == 2'd0)
        else $error("register 0 bypassed on operand A");
    end
    if (exRt == '0) begin
      assert_zero_rt_R5: assert (selB == 2'd0)
        else $error("register 0 bypassed on operand B");
    end
  end
endmodule

// File: tb/hazard_bypass_bench.sv
module hazard_bypass_bench;
  localparam int RB = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [RB-1:0] exRs, exRt, exmemRt, exmemRd, memwbRt, memwbRd, idRs, idRt, idexRt;
  logic exmemUseRd, exmemRegWrite, exmemIsLoad, exmemIsStore;
  logic memwbUseRd, memwbRegWrite, memwbIsLoad;
  logic idReadsRt, idIsStore, idexIsLoad, idexRegWrite, idRegWrite, idMemWrite;
  logic [1:0] selA, selB;
  logic selStore, holdFront, bubble, exRegWriteNext, exMemWriteNext;

  int total = 0;
  int bad = 0;

  hazard_bypass #(.RB(RB)) u_hazard_bypass (.*);

  function automatic logic [RB-1:0] dst(logic [RB-1:0] rt, logic [RB-1:0] rd, logic useRd);
    return useRd ? rd : rt;
  endfunction

  function automatic int refSel(logic [RB-1:0] src);
    logic [RB-1:0] d1, d2;
    d1 = dst(exmemRt, exmemRd, exmemUseRd);
    d2 = dst(memwbRt, memwbRd, memwbUseRd);
    if (src != 0 && exmemRegWrite && !exmemIsLoad && src == d1) return 1;
    if (src != 0 && memwbRegWrite && src == d2) return memwbIsLoad ? 3 : 2;
    return 0;
  endfunction

  function automatic int refStore();
    return (exmemIsStore && memwbIsLoad && memwbRegWrite && memwbRt != 0 && exmemRt == memwbRt) ? 1 : 0;
  endfunction

  function automatic int refStall();
    if (!(idexIsLoad && idexRegWrite) || idexRt == 0) return 0;
    if (idRs == idexRt) return 1;
    if (idReadsRt && !idIsStore && idRt == idexRt) return 1;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearAll();
    {exRs, exRt, exmemRt, exmemRd, memwbRt, memwbRd, idRs, idRt, idexRt} = '0;
    {exmemUseRd, exmemRegWrite, exmemIsLoad, exmemIsStore} = '0;
    {memwbUseRd, memwbRegWrite, memwbIsLoad} = '0;
    {idReadsRt, idIsStore, idexIsLoad, idexRegWrite, idRegWrite, idMemWrite} = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic checkAll();
    check("R1", int'(selA), refSel(exRs));
    check("R3", int'(selB), refSel(exRt));
    check("R8", int'(selStore), refStore());
    check("R9", int'(holdFront), refStall());
    check("R9", int'(bubble), refStall());
    check("R11", int'(exRegWriteNext), (idRegWrite && refStall() == 0) ? 1 : 0);
    check("R11", int'(exMemWriteNext), (idMemWrite && refStall() == 0) ? 1 : 0);
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clearAll();
    settle();
    // idle state: everything quiet
    check("R2", int'(selA), 0);
    check("R2", int'(selB), 0);
    check("R9", int'(holdFront), 0);
    check("R8", int'(selStore), 0);

    // R1: EX/MEM ALU result to A, destination rd (R6)
    clearAll(); exRs = 5'd4; exmemRd = 5'd4; exmemRt = 5'd9; exmemUseRd = 1; exmemRegWrite = 1;
    settle(); check("R1", int'(selA), 1); check("R6", int'(selB), 0);
    // R6: same producer uses rt when useRd is 0
    exmemUseRd = 0; exRt = 5'd9; settle();
    check("R6", int'(selA), 0); check("R3", int'(selB), 1);

    // R2: MEM/WB ALU result and load data
    clearAll(); exRt = 5'd7; memwbRt = 5'd7; memwbRegWrite = 1;
    settle(); check("R2", int'(selB), 2);
    memwbIsLoad = 1; settle(); check("R2", int'(selB), 3);

    // R4: both stages match, EX/MEM wins
    clearAll(); exRs = 5'd3; exmemRt = 5'd3; exmemRegWrite = 1; memwbRt = 5'd3; memwbRegWrite = 1;
    settle(); check("R4", int'(selA), 1);

    // R5: register 0 and write-enable low
    clearAll(); exRs = 5'd0; exmemRt = 5'd0; exmemRegWrite = 1; settle(); check("R5", int'(selA), 0);
    clearAll(); exRs = 5'd6; exmemRt = 5'd6; exmemRegWrite = 0; settle(); check("R5", int'(selA), 0);

    // R7: load in EX/MEM is skipped, older MEM/WB match taken instead
    clearAll(); exRs = 5'd8; exmemRt = 5'd8; exmemRegWrite = 1; exmemIsLoad = 1;
    memwbRt = 5'd8; memwbRegWrite = 1; settle(); check("R7", int'(selA), 2);

    // R8: load then store writing the loaded value
    clearAll(); exmemIsStore = 1; exmemRt = 5'd12; memwbRt = 5'd12; memwbIsLoad = 1; memwbRegWrite = 1;
    settle(); check("R8", int'(selStore), 1);
    memwbIsLoad = 0; settle(); check("R8", int'(selStore), 0);

    // R9 / R11: load-use on rs, with enables killed
    clearAll(); idexIsLoad = 1; idexRegWrite = 1; idexRt = 5'd10; idRs = 5'd10;
    idRegWrite = 1; idMemWrite = 1; settle();
    check("R9", int'(holdFront), 1); check("R9", int'(bubble), 1);
    check("R11", int'(exRegWriteNext), 0); check("R11", int'(exMemWriteNext), 0);

    // R10: store depending only through rt does not stall
    clearAll(); idexIsLoad = 1; idexRegWrite = 1; idexRt = 5'd10; idRt = 5'd10; idReadsRt = 1;
    idIsStore = 1; idRs = 5'd2; idMemWrite = 1; settle();
    check("R10", int'(holdFront), 0); check("R10", int'(exMemWriteNext), 1);
    idRs = 5'd10; settle(); check("R10", int'(holdFront), 1);

    // random mix over a narrow register range
    for (int i = 0; i < 400; i++) begin
      exRs = RB'($urandom_range(0, 3)); exRt = RB'($urandom_range(0, 3));
      exmemRt = RB'($urandom_range(0, 3)); exmemRd = RB'($urandom_range(0, 3));
      memwbRt = RB'($urandom_range(0, 3)); memwbRd = RB'($urandom_range(0, 3));
      idRs = RB'($urandom_range(0, 3)); idRt = RB'($urandom_range(0, 3));
      idexRt = RB'($urandom_range(0, 3));
      {exmemUseRd, exmemRegWrite, exmemIsLoad, exmemIsStore} = 4'($urandom);
      {memwbUseRd, memwbRegWrite, memwbIsLoad} = 3'($urandom);
      {idReadsRt, idIsStore, idexIsLoad, idexRegWrite, idRegWrite, idMemWrite} = 6'($urandom);
      settle();
      checkAll();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule